// File: doc/BRIEF.md
# Double-Late-Write Pipelined Synchronous SRAM

A single-port synchronous memory whose shared data bus can run back-to-back reads and writes in any mix without idle turnaround cycles. Every rising clock edge the block samples an address, a primary enable (active low), two secondary enables whose active level is chosen by two configuration straps, an advance control, a write enable (active low) and one active-low write enable per byte lane. Read data appears on the bus one edge after the read command. Write data is taken from the bus two edges after the write command.

When advance is high the block repeats the type of the previous command at the next address of a four-word linear burst. The data bus is modelled as a registered output word plus an output enable. A separate echo-clock enable output stays on through a primary-enable deselect and turns off only for a deselect caused by the secondary enables. The write pipeline is forwarded into the read path, so a read always sees every write that was issued before it.

Top module: `dlw_sram`

## Requirements
- R1: A read command (advance low, primary enable low, both secondary enables at their programmed level, write enable high) at edge N sets the output enable after edge N+1, with dq_out holding the word at the command address.
- R2: A write command at edge N stores the bus value sampled at edge N+2, and the output enable is low after edge N+1.
- R3: With advance high the cycle repeats the previous command type (read, write, deselect or bank deselect) at the next burst address; after a deselect the block stays deselected.
- R4: Burst addresses step the two low address bits by one modulo 4 from the loaded address (for example 2, 3, 0, 1) while all higher bits stay fixed.
- R5: The data word is eight 9-bit lanes; lane i is bits 9i+8 down to 9i and is written only when bwe_n[i] is low. A write cycle with all bwe_n high changes no memory lane but still advances the burst.
- R6: The straps are sampled only while reset is asserted; a strap value of 1 makes its secondary enable active high and 0 makes it active low. Changing a strap after reset has no effect.
- R7: With advance low, a secondary enable at its inactive level gives a bank deselect regardless of the primary enable; otherwise a high primary enable gives a deselect.
- R8: The output enable is low after deselect, bank deselect and write cycles, and is high only when the echo-clock enable is high.
- R9: The echo-clock enable goes low one edge after a bank deselect cycle (loaded or continued) and stays high through deselect, read and write cycles.
- R10: A read returns the data of a write still in its two-cycle pipeline to the same address, lane by lane, when that write's data is taken at the edge where the read data is captured.
- R11: During and after reset the output enable is low and the echo-clock enable is high, and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all sampling on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset; straps captured while low |
| cfg_pol2 | input | 1 | Strap: active level of en2 (1 = high) |
| cfg_pol3 | input | 1 | Strap: active level of en3 (1 = high) |
| en1_n | input | 1 | Primary enable, active low |
| en2 | input | 1 | Secondary enable with strap-selected level |
| en3 | input | 1 | Secondary enable with strap-selected level |
| adv | input | 1 | 1 = continue burst, 0 = load new command |
| we_n | input | 1 | Write enable, active low |
| bwe_n | input | LANES | Per-lane write enables, active low |
| addr | input | AW | Word address |
| dq_in | input | LANES*LANE_W | Bus value seen by the block (write data) |
| dq_out | output | LANES*LANE_W | Registered read data |
| dq_oe | output | 1 | Bus output enable |
| echo_en | output | 1 | Echo-clock outputs driven when high |

## Verification
The assertions watch, on every cycle, the command-to-output relationships that depend only on control inputs: the output enable after reads, writes and both kinds of deselect, the priority of a bank deselect, the echo-clock enable, its tie to the output enable, and the persistence of state under a burst continue. What data comes back, the lane masking, the burst address order, forwarding from the pending write and the fact that a late strap change is ignored are visible only through the bench's reference memory, which checks every returned word against writes whose data it took from the bus two edges after their commands.

// File: rtl/dlw_sram.sv
module dlw_sram #(
  parameter int AW = 8,
  parameter int LANES = 8,
  parameter int LANE_W = 9,
  localparam int DW = LANES * LANE_W,
  localparam int DEPTH = 1 << AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_pol2,
  input  logic             cfg_pol3,
  input  logic             en1_n,
  input  logic             en2,
  input  logic             en3,
  input  logic             adv,
  input  logic             we_n,
  input  logic [LANES-1:0] bwe_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    dq_in,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe,
  output logic             echo_en
);
  typedef enum logic [1:0] {OP_DESEL, OP_BANK, OP_READ, OP_WRITE} op_t;

  logic             pol2_q, pol3_q;
  op_t              op_q, op_d;
  logic [AW-1:0]    cur_q, addr_d, w2_a;
  logic [LANES-1:0] be_q, w2_be;
  logic             bank_ok, hit;

  assign bank_ok = (en2 == pol2_q) && (en3 == pol3_q);
  assign hit     = (w2_a == cur_q);

  always_comb begin
    op_d   = op_q;
    addr_d = {cur_q[AW-1:2], cur_q[1:0] + 2'd1};
    if (!adv) begin
      addr_d = addr;
      if (!bank_ok)   op_d = OP_BANK;
      else if (en1_n) op_d = OP_DESEL;
      else if (we_n)  op_d = OP_READ;
      else            op_d = OP_WRITE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol2_q  <= cfg_pol2;
      pol3_q  <= cfg_pol3;
      op_q    <= OP_DESEL;
      cur_q   <= '0;
      be_q    <= '0;
      w2_a    <= '0;
      w2_be   <= '0;
      dq_oe   <= 1'b0;
      echo_en <= 1'b1;
    end else begin
      op_q    <= op_d;
      cur_q   <= addr_d;
      be_q    <= (op_d == OP_WRITE) ? ~bwe_n : '0;
      w2_a    <= cur_q;
      w2_be   <= be_q;
      dq_oe   <= (op_q == OP_READ);
      echo_en <= (op_q != OP_BANK);
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] din, rd_q;

    assign din = dq_in[i*LANE_W +: LANE_W];

    always_ff @(posedge clk) begin
      if (rst_n && w2_be[i]) mem[w2_a] <= din;
      if (rst_n && op_q == OP_READ) rd_q <= (w2_be[i] && hit) ? din : mem[cur_q];
    end

    assign dq_out[i*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/dlw_sram_chk.sv
module dlw_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic adv,
  input logic en1_n,
  input logic en2,
  input logic en3,
  input logic we_n,
  input logic pol2,
  input logic pol3,
  input logic dq_oe,
  input logic echo_en
);
  logic sel_ok;
  assign sel_ok = (en2 == pol2) && (en3 == pol3);

  assert_read_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && sel_ok && !en1_n && we_n) |-> ##2 dq_oe);

  assert_write_hiz_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && sel_ok && !en1_n && !we_n) |-> ##2 (!dq_oe && echo_en));

  assert_desel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && sel_ok && en1_n) |-> ##2 (!dq_oe && echo_en));

  assert_bank_echo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !sel_ok) |-> ##2 (!dq_oe && !echo_en));

  assert_continue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> ##2 (dq_oe == $past(dq_oe) && echo_en == $past(echo_en)));

  assert_oe_echo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> echo_en);

  assert_reset_state_R11: assert property (@(posedge clk)
    !rst_n |=> (!dq_oe && echo_en));
endmodule

bind dlw_sram dlw_sram_chk chk_i (
  .clk(clk), .rst_n(rst_n), .adv(adv), .en1_n(en1_n), .en2(en2), .en3(en3),
  .we_n(we_n), .pol2(pol2_q), .pol3(pol3_q), .dq_oe(dq_oe), .echo_en(echo_en)
);

// File: tb/dlw_sram_tb_top.sv
module dlw_sram_tb_top;
  localparam int AW = 8;
  localparam int LANES = 8;
  localparam int LW = 9;
  localparam int DW = LANES * LW;

  logic clk = 1'b0, rst_n = 1'b0, pol2 = 1'b1, pol3 = 1'b0;
  logic en1_n = 1'b1, en2 = 1'b1, en3 = 1'b0, adv = 1'b0, we_n = 1'b1;
  logic [LANES-1:0] bwe_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe, echo_en;
  logic g2 = 1'b1, g3 = 1'b0;

  int checks = 0, errors = 0, cyc_n = 0, ncyc = 0;
  string cur_req = "R11";

  always #2 clk = ~clk;

  dlw_sram #(.AW(AW), .LANES(LANES), .LANE_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_pol2(pol2), .cfg_pol3(pol3),
    .en1_n(en1_n), .en2(en2), .en3(en3), .adv(adv), .we_n(we_n),
    .bwe_n(bwe_n), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .echo_en(echo_en)
  );

  typedef enum int {MD, MB, MR, MW} mop_t;
  mop_t prev_op = MD;
  int prev_a = 0;
  logic pol2_m = 1'b0, pol3_m = 1'b0;
  logic [DW-1:0] mm [int];
  bit known [int];
  int qa[$];
  int qd[$];
  logic [LANES-1:0] qm[$];
  logic exp_oe = 1'b0, exp_echo = 1'b1;
  bit exp_known = 0, started = 0;
  logic [DW-1:0] exp_dq = '0;

  always @(posedge clk) begin
    mop_t op;
    int a, wa;
    logic [LANES-1:0] m;
    if (!rst_n) begin
      pol2_m = pol2; pol3_m = pol3;
      prev_op = MD;
      qa.delete(); qd.delete(); qm.delete();
      exp_oe = 1'b0; exp_echo = 1'b1;
      started = 1;
    end else begin
      cyc_n++;
      while (qd.size() > 0 && qd[0] == cyc_n) begin
        wa = qa.pop_front(); m = qm.pop_front(); void'(qd.pop_front());
        if (!mm.exists(wa)) begin mm[wa] = '0; known[wa] = 0; end
        for (int i = 0; i < LANES; i++)
          if (m[i]) mm[wa][i*LW +: LW] = dq_in[i*LW +: LW];
        if (m == '1) known[wa] = 1;
      end
      exp_oe = (prev_op == MR);
      exp_echo = (prev_op != MB);
      exp_known = exp_oe && known.exists(prev_a) && known[prev_a];
      if (exp_known) exp_dq = mm[prev_a];
      if (!adv) begin
        if (!((en2 == pol2_m) && (en3 == pol3_m))) op = MB;
        else if (en1_n) op = MD;
        else if (we_n) op = MR;
        else op = MW;
        a = int'(addr);
      end else begin
        op = prev_op;
        a = (prev_a & ~3) | ((prev_a + 1) & 3);
      end
      if (op == MW) begin qa.push_back(a); qm.push_back(~bwe_n); qd.push_back(cyc_n + 2); end
      prev_op = op; prev_a = a;
    end
  end

  task automatic check(bit ok, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    ncyc++;
    if (ncyc > 150000) begin
      checks++; errors++;
      $display("FAIL %s watchdog actual %0d expected %0d", cur_req, ncyc, 150000);
      finish_run();
    end
    if (started) begin
      check(dq_oe === exp_oe, "dq_oe", DW'(dq_oe), DW'(exp_oe));
      check(echo_en === exp_echo, "echo_en", DW'(echo_en), DW'(exp_echo));
      if (exp_known) check(dq_out === exp_dq, "dq_out", dq_out, exp_dq);
    end
  end

  task automatic step(bit a, bit e1, bit e2, bit e3, bit w, logic [LANES-1:0] be, int ad);
    @(negedge clk);
    adv = a; en1_n = e1; en2 = e2; en3 = e3; we_n = w; bwe_n = be; addr = AW'(ad);
    dq_in = {8'($urandom), 32'($urandom), 32'($urandom)};
  endtask

  task automatic rd(int ad);                      step(0, 0, g2, g3, 1, '1, ad);  endtask
  task automatic wr(int ad, logic [LANES-1:0] be); step(0, 0, g2, g3, 0, be, ad);  endtask
  task automatic cont(logic [LANES-1:0] be);       step(1, 0, g2, g3, 0, be, 0);   endtask
  task automatic desel();                          step(0, 1, g2, g3, 1, '1, 0);   endtask
  task automatic bank();                           step(0, 0, ~g2, g3, 1, '1, 0);  endtask

  initial begin
    cur_req = "R11";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    desel();

    cur_req = "R2";
    for (int b = 0; b < 16; b++) begin
      wr(b * 4, '0); cont('0); cont('0); cont('0);
    end
    desel(); desel();

    cur_req = "R1";
    rd(5); rd(17); rd(33); desel(); desel();

    cur_req = "R4";
    rd(46); cont('1); cont('1); cont('1);
    wr(27, '0); cont('0); cont('0); cont('0); desel(); desel();
    rd(24); cont('1); cont('1); cont('1); desel(); desel();

    cur_req = "R10";
    wr(9, '0); rd(9); desel();
    wr(10, '0); desel(); rd(10); desel();
    wr(11, 8'h0F); rd(11); desel();
    wr(12, '0); rd(12); wr(12, '0); rd(12); desel(); desel();

    cur_req = "R5";
    wr(20, 8'b1010_0110); desel(); desel(); rd(20); desel();
    wr(24, '1); cont(8'hF0); cont('1); cont(8'h0F); desel(); desel();
    rd(24); cont('1); cont('1); cont('1); desel(); desel();

    cur_req = "R8";
    rd(1); wr(2, '0); rd(3); wr(4, '0); desel(); desel(); rd(2); rd(4); desel();

    cur_req = "R7";
    step(0, 1, ~g2, g3, 1, '1, 0);
    step(0, 1, g2, ~g3, 1, '1, 0);
    desel(); rd(7); desel();

    cur_req = "R9";
    bank(); cont('1); cont('1); rd(5); desel(); cont('1); cont('1); rd(6); desel(); desel();

    cur_req = "R3";
    rd(40); desel(); cont('0); cont('0);
    wr(41, '0); cont('0); desel(); desel();
    rd(41); cont('1); desel(); desel();

    cur_req = "R6";
    @(negedge clk);
    rst_n = 1'b0; pol2 = 1'b0; pol3 = 1'b1; g2 = 1'b0; g3 = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd(5);
    step(0, 0, 1, 1, 1, '1, 6);
    rd(6);
    pol2 = 1'b1;
    rd(7);
    step(0, 0, 1, 1, 1, '1, 8);
    wr(30, 8'h3C); desel(); desel(); rd(30);
    desel(); desel();

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule